// File: doc/BRIEF.md
# Write-Only I2C Control Register Target

This block is an I2C target that accepts write transfers only. It fills a bank of eight 8-bit control registers for a two-phase piezo motor pulse engine. SCL and SDA are sampled on a fast system clock through two-flop synchronisers. START and STOP are found from edges of the synchronised lines. The 7-bit target address is 0x54 when the strap input `addr_pin` is low and 0x55 when it is high. The target acknowledges the address byte of a write and every byte after it. It never stretches the clock and never returns data.

Within a transfer, the byte after the address is a register pointer. Each later byte is stored at the pointer, and the pointer then advances by one, stopping at the last register. When the low pulse-count byte is written, `pulse_cnt_load` pulses for one cycle. The motor engine can then take the full 11-bit count (three bits from the high byte, eight from the low byte) as one unit. Holding `standby_n` low clears the pulse-width and phase-shift registers.

The controller is a state machine with these states:

- ST_IDLE: waits for START.
- ST_ADDR: shifts in the address byte.
- ST_ADDR_ACK: drives the address acknowledge.
- ST_PTR: shifts in the pointer byte.
- ST_PTR_ACK: drives the pointer acknowledge.
- ST_DATA: shifts in a data byte.
- ST_DATA_ACK: drives the data acknowledge.
- ST_IGNORE: stays silent until the bus is free.

It has these transitions:

- START from any state goes to ST_ADDR.
- STOP from any state goes to ST_IDLE.
- At the eighth SCL fall, ST_ADDR goes to ST_ADDR_ACK on an address match with the write bit, and to ST_IGNORE otherwise.
- At the eighth SCL fall, ST_PTR goes to ST_PTR_ACK.
- At the eighth SCL fall, ST_DATA goes to ST_DATA_ACK, and the register write happens on this transition.
- At the ninth SCL fall, each ACK state moves on: ST_ADDR_ACK to ST_PTR, ST_PTR_ACK to ST_DATA, and ST_DATA_ACK back to ST_DATA.

Top module: `i2c_wr_regbank`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal 0x54 with `addr_pin` low, or 0x55 with `addr_pin` high, and whose LSB (R/W) is 0. So 0xA8 or 0xAA is acknowledged. Bits arrive MSB first.
- R2: An address byte with R/W = 1, or with a different address, gets no acknowledge. No byte after it, up to the next START or STOP, is acknowledged or changes any register.
- R3: The acknowledge (`sda_pull_low` high) starts only after the SCL falling edge that ends the eighth bit. It is held through the ninth SCL high phase.
- R4: `sda_pull_low` is released after the ninth SCL falling edge, or at START or STOP. It is never held into the next byte.
- R5: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. STOP returns the target to idle, so clocked bytes without a new START are ignored. A repeated START discards a partly received byte and restarts the address phase.
- R6: The first byte after the address sets the register pointer. Each following byte is written to the pointer, and the pointer then increments. Register indexes are 0 control, 1 period low, 2 pulse count high, 3 pulse count low, 4 pulse width, 5 phase shift, 6 offset/mode and 7 hybrid speed.
- R7: After reset, register 7 holds 0x80 and all other registers hold 0x00.
- R8: While `standby_n` is low, registers 4 and 5 are forced to 0x00. The other registers keep their values.
- R9: `pulse_cnt_load` is high for exactly one cycle after each write to register 3. In that cycle, registers 2 and 3 already show the new values.
- R10: Bytes written with a pointer above 7 are acknowledged and discarded. The pointer never increments past 7, so extra bytes in a page write keep overwriting register 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | I2C clock line as seen on the pad |
| sda_in | input | 1 | I2C data line as seen on the pad |
| addr_pin | input | 1 | Strap giving the address LSB |
| standby_n | input | 1 | Low clears pulse width and phase shift |
| sda_pull_low | output | 1 | Open-drain enable; high pulls SDA low |
| ctrl_reg | output | 8 | Register 0, control |
| period_lo_reg | output | 8 | Register 1, period low byte |
| pulse_cnt_hi | output | 8 | Register 2, pulse count high byte |
| pulse_cnt_lo | output | 8 | Register 3, pulse count low byte |
| pulse_width | output | 8 | Register 4, pulse width |
| phase_shift | output | 8 | Register 5, phase shift |
| offset_mode | output | 8 | Register 6, period offset and mode bits |
| hybrid_speed | output | 8 | Register 7, hybrid speed |
| pulse_cnt_load | output | 1 | One-cycle strobe after a register 3 write |

## Verification
The assertions assume that SCL and SDA each stay stable for several system clocks between changes. Every bus edge then yields exactly one synchronised edge event, and a START or STOP is never confused with a data bit. They also assume SDA changes only while SCL is low, except to form START or STOP. The bench drives the bus with a quarter-bit time of ten system clocks. It moves data only in the middle of the SCL low phase, and it raises SDA before raising SCL when it issues a repeated START, so no spurious STOP appears.

// File: rtl/motor_i2c_pkg.sv
package motor_i2c_pkg;
    localparam int REG_W       = 8;
    localparam int NUM_REGS    = 8;
    localparam int IDX_PCNT_LO = 3;
    localparam int IDX_PWIDTH  = 4;
    localparam int IDX_PHASE   = 5;
    localparam int IDX_HYBRID  = 7;
    localparam logic [5:0]       DEV_ADDR_HI = 6'b101010;
    localparam logic [REG_W-1:0] HYBRID_RST  = 8'h80;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } i2c_state_e;

    function automatic logic [REG_W-1:0] reg_reset_value(input int idx);
        return (idx == IDX_HYBRID) ? HYBRID_RST : '0;
    endfunction
endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] now_v;
    logic [LINES-1:0] prev_v;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] pipe_q;
        always_ff @(posedge clk) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= {pipe_q[STAGES-1:0], raw[g]};
        end
        assign now_v[g]  = pipe_q[STAGES-1];
        assign prev_v[g] = pipe_q[STAGES];
    end

    assign sda_s     = now_v[1];
    assign scl_rise  = now_v[0] & ~prev_v[0];
    assign scl_fall  = ~now_v[0] & prev_v[0];
    assign start_det = now_v[0] & prev_v[0] & ~now_v[1] & prev_v[1];
    assign stop_det  = now_v[0] & prev_v[0] & now_v[1] & ~prev_v[1];
endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
    import motor_i2c_pkg::*;
#(
    parameter int BYTE_W = REG_W,
    parameter int NREG   = NUM_REGS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_s,
    input  logic              addr_pin,
    output logic              sda_pull_low,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(BYTE_W);
    localparam logic [BYTE_W-1:0] LAST_IDX = BYTE_W'(NREG - 1);

    i2c_state_e        state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [BYTE_W-1:0] shift_q;
    logic [BYTE_W-1:0] ptr_q;
    logic              byte_done;
    logic              addr_hit;
    logic              shifting;
    logic              in_ack;

    assign byte_done = scl_fall && (bit_cnt_q == FULL_CNT);
    assign addr_hit  = (shift_q == {DEV_ADDR_HI, addr_pin, 1'b0});
    assign shifting  = (state_q == ST_ADDR) || (state_q == ST_PTR) || (state_q == ST_DATA);
    assign in_ack    = (state_q == ST_ADDR_ACK) || (state_q == ST_PTR_ACK) || (state_q == ST_DATA_ACK);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall)  state_d = ST_PTR;
                ST_PTR:      if (byte_done) state_d = ST_PTR_ACK;
                ST_PTR_ACK:  if (scl_fall)  state_d = ST_DATA;
                ST_DATA:     if (byte_done) state_d = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall)  state_d = ST_DATA;
                ST_IGNORE:   state_d = ST_IGNORE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // byte assembly and register pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            shift_q   <= '0;
            ptr_q     <= '0;
        end else begin
            if (start_det || (in_ack && scl_fall)) begin
                bit_cnt_q <= '0;
            end else if (shifting && scl_rise && (bit_cnt_q != FULL_CNT)) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
                shift_q   <= {shift_q[BYTE_W-2:0], sda_s};
            end
            if (!start_det && !stop_det && byte_done) begin
                if (state_q == ST_PTR) begin
                    ptr_q <= shift_q;
                end else if ((state_q == ST_DATA) && (ptr_q < LAST_IDX)) begin
                    ptr_q <= ptr_q + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        sda_pull_low = in_ack;
        wr_en        = (state_q == ST_DATA) && (state_d == ST_DATA_ACK);
        wr_addr      = ptr_q;
        wr_data      = shift_q;
    end

    assert_ack_after_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_low) |-> $past(scl_fall));

    assert_ack_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull_low) |-> $past(scl_fall || start_det || stop_det));

    assert_stop_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state_q == ST_IDLE));

    assert_ptr_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr >= LAST_IDX)) |=> $stable(ptr_q));
endmodule

// File: rtl/motor_reg_bank.sv
module motor_reg_bank
    import motor_i2c_pkg::*;
#(
    parameter int BYTE_W = REG_W,
    parameter int NREG   = NUM_REGS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   standby_n,
    input  logic                   wr_en,
    input  logic [BYTE_W-1:0]      wr_addr,
    input  logic [BYTE_W-1:0]      wr_data,
    output logic [NREG*BYTE_W-1:0] regs_flat,
    output logic                   pcnt_load
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [BYTE_W-1:0] IDX = BYTE_W'(g);
        localparam bit CLEAR_ON_STBY = (g == IDX_PWIDTH) || (g == IDX_PHASE);
        logic [BYTE_W-1:0] val_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= BYTE_W'(reg_reset_value(g));
            end else if (CLEAR_ON_STBY && !standby_n) begin
                val_q <= '0;
            end else if (wr_en && (wr_addr == IDX)) begin
                val_q <= wr_data;
            end
        end
        assign regs_flat[g*BYTE_W +: BYTE_W] = val_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pcnt_load <= 1'b0;
        else        pcnt_load <= wr_en && (wr_addr == BYTE_W'(IDX_PCNT_LO));
    end

    assert_load_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt_load |=> !pcnt_load);

    assert_load_follows_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt_load |-> $past(wr_en));

    assert_standby_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !standby_n |=> (regs_flat[IDX_PWIDTH*BYTE_W +: BYTE_W] == '0)
                    && (regs_flat[IDX_PHASE*BYTE_W +: BYTE_W] == '0));

    assert_high_ptr_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr >= BYTE_W'(NREG)) && standby_n) |=> $stable(regs_flat));
endmodule

// File: rtl/i2c_wr_regbank.sv
module i2c_wr_regbank
    import motor_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             addr_pin,
    input  logic             standby_n,
    output logic             sda_pull_low,
    output logic [REG_W-1:0] ctrl_reg,
    output logic [REG_W-1:0] period_lo_reg,
    output logic [REG_W-1:0] pulse_cnt_hi,
    output logic [REG_W-1:0] pulse_cnt_lo,
    output logic [REG_W-1:0] pulse_width,
    output logic [REG_W-1:0] phase_shift,
    output logic [REG_W-1:0] offset_mode,
    output logic [REG_W-1:0] hybrid_speed,
    output logic             pulse_cnt_load
);
    localparam int FLAT_W = NUM_REGS * REG_W;

    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [REG_W-1:0]  wr_addr, wr_data;
    logic [FLAT_W-1:0] regs_flat;

    i2c_bus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_wr_fsm #(.BYTE_W(REG_W), .NREG(NUM_REGS)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .sda_s        (sda_s),
        .addr_pin     (addr_pin),
        .sda_pull_low (sda_pull_low),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data)
    );

    motor_reg_bank #(.BYTE_W(REG_W), .NREG(NUM_REGS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby_n (standby_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .regs_flat (regs_flat),
        .pcnt_load (pulse_cnt_load)
    );

    assign ctrl_reg      = regs_flat[0*REG_W +: REG_W];
    assign period_lo_reg = regs_flat[1*REG_W +: REG_W];
    assign pulse_cnt_hi  = regs_flat[2*REG_W +: REG_W];
    assign pulse_cnt_lo  = regs_flat[3*REG_W +: REG_W];
    assign pulse_width   = regs_flat[4*REG_W +: REG_W];
    assign phase_shift   = regs_flat[5*REG_W +: REG_W];
    assign offset_mode   = regs_flat[6*REG_W +: REG_W];
    assign hybrid_speed  = regs_flat[7*REG_W +: REG_W];
endmodule

// File: tb/sim_i2c_wr_regbank.sv
module sim_i2c_wr_regbank;
    localparam int Q = 10;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, scl_o = 1'b1, sda_o = 1'b1, addr_pin = 1'b0, standby_n = 1'b1;
    logic sda_pull_low, pulse_cnt_load;
    logic [7:0] ctrl_reg, period_lo_reg, pulse_cnt_hi, pulse_cnt_lo;
    logic [7:0] pulse_width, phase_shift, offset_mode, hybrid_speed;
    wire  sda_line = sda_o & ~sda_pull_low;

    i2c_wr_regbank u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_o), .sda_in(sda_line),
        .addr_pin(addr_pin), .standby_n(standby_n), .sda_pull_low(sda_pull_low),
        .ctrl_reg(ctrl_reg), .period_lo_reg(period_lo_reg),
        .pulse_cnt_hi(pulse_cnt_hi), .pulse_cnt_lo(pulse_cnt_lo),
        .pulse_width(pulse_width), .phase_shift(phase_shift),
        .offset_mode(offset_mode), .hybrid_speed(hybrid_speed),
        .pulse_cnt_load(pulse_cnt_load)
    );

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [7:0]  model [8];
    logic [15:0] exp_q [$];
    logic        prev_load = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] reg_out(input int i);
        case (i)
            0: return ctrl_reg;     1: return period_lo_reg;
            2: return pulse_cnt_hi; 3: return pulse_cnt_lo;
            4: return pulse_width;  5: return phase_shift;
            6: return offset_mode;  default: return hybrid_speed;
        endcase
    endfunction

    task automatic check_regs(input string req);
        for (int i = 0; i < 8; i++) chk(reg_out(i) == model[i], req, 16'(reg_out(i)), 16'(model[i]));
    endtask

    task automatic bus_start();
        sda_o = 1'b1; wq(Q); scl_o = 1'b1; wq(Q); sda_o = 1'b0; wq(Q); scl_o = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_o = 1'b0; wq(Q); scl_o = 1'b1; wq(Q); sda_o = 1'b1; wq(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_o = b; wq(Q); scl_o = 1'b1; wq(2 * Q); scl_o = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        bit got;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_o = 1'b1; wq(Q); scl_o = 1'b1; wq(Q);
        got = ~sda_line;
        chk(got == exp_ack, req, 16'(got), 16'(exp_ack));
        wq(Q); scl_o = 1'b0; wq(Q);
        if (exp_ack) chk(sda_pull_low == 1'b0, "R4 release", 16'(sda_pull_low), 16'h0);
    endtask

    // driver: one acknowledged page write, model and scoreboard updated per byte
    task automatic page_write(input logic [7:0] ab, input logic [7:0] p, input int n,
                              input logic [7:0] d0, input logic [7:0] d1,
                              input logic [7:0] d2, input logic [7:0] d3);
        logic [7:0] d [4];
        logic [7:0] ptr;
        d = '{d0, d1, d2, d3};
        ptr = p;
        bus_start();
        send_byte(ab, 1'b1, "R1 addr ack");
        send_byte(p, 1'b1, "R6 ptr ack");
        for (int k = 0; k < n; k++) begin
            if (ptr < 8) model[ptr[2:0]] = d[k];
            if (ptr == 8'd3) exp_q.push_back({model[2], model[3]});
            send_byte(d[k], 1'b1, "R6 data ack");
            if (ptr < 8'd7) ptr = ptr + 1'b1;
        end
        bus_stop();
    endtask

    // monitor: scoreboard for the pulse-count load strobe (R9)
    always @(negedge clk) begin
        if (rst_n) begin
            if (pulse_cnt_load) begin
                if (prev_load) chk(1'b0, "R9 strobe width", 16'h2, 16'h1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected strobe", {pulse_cnt_hi, pulse_cnt_lo}, 16'h0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk({pulse_cnt_hi, pulse_cnt_lo} == e, "R9 count on strobe", {pulse_cnt_hi, pulse_cnt_lo}, e);
                end
            end
            prev_load = pulse_cnt_load;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = (i == 7) ? 8'h80 : 8'h00;
        wq(5); rst_n = 1'b1; wq(5);

        // R7 reset values
        check_regs("R7 reset");
        chk(sda_pull_low == 1'b0, "R7 sda idle", 16'(sda_pull_low), 16'h0);

        // R1 R6 R9 example stream
        page_write(8'hA8, 8'h02, 2, 8'h77, 8'hFF, 8'h00, 8'h00);
        check_regs("R6 pcnt pair");

        // R6 page write across 4..7
        page_write(8'hA8, 8'h04, 4, 8'h11, 8'h22, 8'h33, 8'h44);
        check_regs("R6 page");

        // R9 single low byte
        page_write(8'hA8, 8'h03, 1, 8'h12, 8'h00, 8'h00, 8'h00);
        check_regs("R9 low byte");

        // R10 pointer saturates at 7
        page_write(8'hA8, 8'h06, 3, 8'hAA, 8'hBB, 8'hCC, 8'h00);
        check_regs("R10 saturate");

        // R10 pointer above 7 discarded but acknowledged
        page_write(8'hA8, 8'h09, 2, 8'h5A, 8'hA5, 8'h00, 8'h00);
        check_regs("R10 high ptr");

        // R2 address mismatch with strap high
        addr_pin = 1'b1;
        bus_start();
        send_byte(8'hA8, 1'b0, "R2 wrong addr nack");
        send_byte(8'h00, 1'b0, "R2 ignored byte");
        send_byte(8'h66, 1'b0, "R2 ignored byte");
        bus_stop();
        check_regs("R2 no change");

        // R1 strap high address
        page_write(8'hAA, 8'h00, 1, 8'h3C, 8'h00, 8'h00, 8'h00);
        check_regs("R1 strap high");

        // R2 read request
        bus_start();
        send_byte(8'hAB, 1'b0, "R2 read nack");
        send_byte(8'h01, 1'b0, "R2 ignored after read");
        bus_stop();
        check_regs("R2 read no change");

        // R5 bytes clocked after STOP without START are ignored
        send_byte(8'hAA, 1'b0, "R5 no start nack");
        send_byte(8'h01, 1'b0, "R5 no start nack");
        check_regs("R5 idle no change");

        // R5 repeated START mid-byte
        bus_start();
        send_byte(8'hAA, 1'b1, "R5 addr ack");
        send_byte(8'h01, 1'b1, "R5 ptr ack");
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_start();
        check_regs("R5 partial dropped");
        send_byte(8'hAA, 1'b1, "R5 restart addr ack");
        send_byte(8'h01, 1'b1, "R5 restart ptr ack");
        model[1] = 8'h5C;
        send_byte(8'h5C, 1'b1, "R5 restart data ack");
        bus_stop();
        check_regs("R5 restart write");

        // R8 standby clears pulse width and phase shift only
        standby_n = 1'b0; wq(3);
        model[4] = 8'h00; model[5] = 8'h00;
        check_regs("R8 standby");
        standby_n = 1'b1; wq(3);
        check_regs("R8 after standby");

        wq(20);
        chk(exp_q.size() == 0, "R9 strobes seen", 16'(exp_q.size()), 16'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule